// File: doc/BRIEF.md
# Single-Bit Operation and Mask Decode Unit

This execution unit works on 32-bit words. It applies one of eight single-bit operations to a destination value at a bit position taken from a source value. It can also turn a small source field of 2, 3, 4 or 5 bits into a one-hot mask. A zero flag and a carry flag are kept inside the unit. Each flag is rewritten only when its own enable is high for the operation. The carry flag returns extra information: the bit operations put the former value of the chosen bit in carry. A decode copies the two source bits just above the decoded field into the zero and carry flags, so software can test them as an out-of-range marker.

An issuing stage presents one operation per cycle with `valid_in` high. The result and the new flags show up on the registered outputs one clock later, with `valid_out` high. The four conditional-set operations read the flag values the unit holds when the operation is issued. A flag written by one operation is therefore seen by the next operation issued on the following cycle.

Top module: `bitop_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result`, `z_flag`, `c_flag` and `valid_out` become 0.
- R2: An operation accepted with `valid_in` high at a rising edge shows its result and flags after that edge, and `valid_out` is high for exactly that one cycle for each accepted operation.
- R3: With `dec_mode` = 0 the bit position is `s_val[4:0]`, and `bit_op` selects the operation: 0 isolate (D with every other bit cleared), 1 invert, 2 clear, 3 set. The other bits of D pass through unchanged.
- R4: `bit_op` 4, 5, 6 and 7 write into the chosen bit, in that order, the held carry flag, its inverse, the held zero flag, and its inverse. The flag values used are the ones held when the operation is accepted.
- R5: For every bit operation with `wc_en` high, the new carry is the value the chosen bit of D had before the operation.
- R6: For every bit operation with `wz_en` high, the new zero flag is 1 exactly when the whole 32-bit result is zero.
- R7: With `dec_mode` = 1, `dec_width` code w selects field width n = w + 2. The result is a word with the single bit at position `s_val[n-1:0]` set and every other bit 0. `bit_op` is ignored.
- R8: For a decode of width n, the new zero flag is `s_val[n]` and the new carry is `s_val[n+1]`, each only when its enable is high.
- R9: A flag whose enable is low keeps its value. While `valid_in` is low, `result` and both flags keep their values.
- R10: Bits 31 to 5 of `s_val` do not affect a bit operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation present this cycle |
| dec_mode | input | 1 | 1 selects a mask decode, 0 a bit operation |
| dec_width | input | 2 | Decode field width code (width = code + 2) |
| bit_op | input | 3 | Bit operation select |
| d_val | input | 32 | Destination operand |
| s_val | input | 32 | Source operand or resolved immediate |
| wz_en | input | 1 | Write enable for the zero flag |
| wc_en | input | 1 | Write enable for the carry flag |
| result | output | 32 | Registered result word |
| z_flag | output | 1 | Held zero flag |
| c_flag | output | 1 | Held carry flag |
| valid_out | output | 1 | Result of an accepted operation is present |

## Verification
Every result and both flags are due exactly one rising edge after the edge that accepts the operation. The held flags that the conditional sets read change at that same edge. The driver applies an operation at a falling edge and pushes the expected item at once. The monitor samples at the next falling edge, half a cycle after the registers load. It pops one item each time it sees `valid_out`, so each comparison lands on the cycle the result is due. The reference model updates its own flag copy when it pushes, so back-to-back conditional sets are predicted from the flags the unit holds at issue. The hold checks are made only after the queue drains and several idle cycles have passed.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned IDX_W     = $clog2(WORD_W);
    localparam int unsigned DEC_MIN   = 2;
    localparam int unsigned DEC_COUNT = 4;
    localparam int unsigned DEC_SEL_W = $clog2(DEC_COUNT);
    localparam int unsigned OP_W      = 3;

    typedef enum logic [OP_W-1:0] {
        BOP_ISOLATE = 3'd0,
        BOP_INVERT  = 3'd1,
        BOP_CLEAR   = 3'd2,
        BOP_SET     = 3'd3,
        BOP_SET_C   = 3'd4,
        BOP_SET_NC  = 3'd5,
        BOP_SET_Z   = 3'd6,
        BOP_SET_NZ  = 3'd7
    } bop_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              zf;
        logic              cf;
    } unit_res_t;

    function automatic logic [WORD_W-1:0] one_hot(input logic [IDX_W-1:0] pos);
        logic [WORD_W-1:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/bitop_bitunit.sv
module bitop_bitunit
    import bitop_pkg::*;
(
    input  logic [WORD_W-1:0] d_in,
    input  logic [WORD_W-1:0] s_in,
    input  bop_e              op,
    input  logic              zf_now,
    input  logic              cf_now,
    output unit_res_t         res
);
    logic [IDX_W-1:0]  pos;
    logic [WORD_W-1:0] sel_mask;
    logic              old_bit;
    logic              new_bit;
    logic [WORD_W-1:0] value;

    assign pos      = s_in[IDX_W-1:0];
    assign sel_mask = one_hot(pos);
    assign old_bit  = |(d_in & sel_mask);

    always_comb begin
        unique case (op)
            BOP_INVERT: new_bit = ~old_bit;
            BOP_CLEAR:  new_bit = 1'b0;
            BOP_SET:    new_bit = 1'b1;
            BOP_SET_C:  new_bit = cf_now;
            BOP_SET_NC: new_bit = ~cf_now;
            BOP_SET_Z:  new_bit = zf_now;
            BOP_SET_NZ: new_bit = ~zf_now;
            default:    new_bit = old_bit;
        endcase
    end

    always_comb begin
        if (op == BOP_ISOLATE)
            value = d_in & sel_mask;
        else
            value = (d_in & ~sel_mask) | (new_bit ? sel_mask : '0);
    end

    assign res.value = value;
    assign res.zf    = (value == '0);
    assign res.cf    = old_bit;

endmodule

// File: rtl/bitop_decunit.sv
module bitop_decunit
    import bitop_pkg::*;
(
    input  logic [WORD_W-1:0]    s_in,
    input  logic [DEC_SEL_W-1:0] width_sel,
    output unit_res_t            res
);
    unit_res_t cand [DEC_COUNT];

    for (genvar g = 0; g < DEC_COUNT; g++) begin : g_width
        localparam int unsigned FW = DEC_MIN + g;
        logic [IDX_W-1:0] pos;
        assign pos = IDX_W'(s_in[FW-1:0]);
        assign cand[g].value = one_hot(pos);
        assign cand[g].zf    = s_in[FW];
        assign cand[g].cf    = s_in[FW+1];
    end

    assign res = cand[width_sel];

endmodule

// File: rtl/bitop_state.sv
module bitop_state
    import bitop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              wz,
    input  logic              wc,
    input  unit_res_t         nxt,
    output logic [WORD_W-1:0] value_q,
    output logic              zf_q,
    output logic              cf_q,
    output logic              vld_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            zf_q    <= 1'b0;
            cf_q    <= 1'b0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= load;
            if (load) begin
                value_q <= nxt.value;
                if (wz) zf_q <= nxt.zf;
                if (wc) cf_q <= nxt.cf;
            end
        end
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_in,
    input  logic        dec_mode,
    input  logic [1:0]  dec_width,
    input  logic [2:0]  bit_op,
    input  logic [31:0] d_val,
    input  logic [31:0] s_val,
    input  logic        wz_en,
    input  logic        wc_en,
    output logic [31:0] result,
    output logic        z_flag,
    output logic        c_flag,
    output logic        valid_out
);
    unit_res_t bit_res;
    unit_res_t dec_res;
    unit_res_t sel_res;

    bitop_bitunit u_bit (
        .d_in   (d_val),
        .s_in   (s_val),
        .op     (bop_e'(bit_op)),
        .zf_now (z_flag),
        .cf_now (c_flag),
        .res    (bit_res)
    );

    bitop_decunit u_dec (
        .s_in      (s_val),
        .width_sel (dec_width),
        .res       (dec_res)
    );

    assign sel_res = dec_mode ? dec_res : bit_res;

    bitop_state u_state (
        .clk     (clk),
        .rst     (rst),
        .load    (valid_in),
        .wz      (wz_en),
        .wc      (wc_en),
        .nxt     (sel_res),
        .value_q (result),
        .zf_q    (z_flag),
        .cf_q    (c_flag),
        .vld_q   (valid_out)
    );

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_in,
    input logic        dec_mode,
    input logic [2:0]  bit_op,
    input logic [31:0] d_val,
    input logic [31:0] s_val,
    input logic        wz_en,
    input logic        wc_en,
    input logic [31:0] result,
    input logic        z_flag,
    input logic        c_flag,
    input logic        valid_out
);
    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    // R9
    z_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_in && wz_en) |=> $stable(z_flag));

    // R9
    c_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_in && wc_en) |=> $stable(c_flag));

    // R7
    dec_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && dec_mode) |=> ($countones(result) == 1));

    // R5
    old_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !dec_mode && wc_en) |=> (c_flag == $past(d_val[s_val[4:0]])));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !dec_mode && wz_en) |=> (z_flag == (result == 32'd0)));

    // R3
    clear_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !dec_mode && bit_op == 3'd2) |=> (result[$past(s_val[4:0])] == 1'b0));

endmodule

bind bitop_unit bitop_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .dec_mode  (dec_mode),
    .bit_op    (bit_op),
    .d_val     (d_val),
    .s_val     (s_val),
    .wz_en     (wz_en),
    .wc_en     (wc_en),
    .result    (result),
    .z_flag    (z_flag),
    .c_flag    (c_flag),
    .valid_out (valid_out)
);

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic        dec_mode = 1'b0;
    logic [1:0]  dec_width = '0;
    logic [2:0]  bit_op = '0;
    logic [31:0] d_val = '0;
    logic [31:0] s_val = '0;
    logic        wz_en = 1'b0;
    logic        wc_en = 1'b0;
    logic [31:0] result;
    logic        z_flag;
    logic        c_flag;
    logic        valid_out;

    always #5 clk = ~clk;

    bitop_unit u_bitop_unit (
        .clk(clk), .rst(rst), .valid_in(valid_in), .dec_mode(dec_mode),
        .dec_width(dec_width), .bit_op(bit_op), .d_val(d_val), .s_val(s_val),
        .wz_en(wz_en), .wc_en(wc_en), .result(result), .z_flag(z_flag),
        .c_flag(c_flag), .valid_out(valid_out)
    );

    typedef struct {
        logic [31:0] res;
        logic        z;
        logic        c;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    logic [31:0] m_res = '0;
    logic        m_z   = 1'b0;
    logic        m_c   = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input bit dm, input logic [1:0] w, input logic [2:0] op,
                         input logic [31:0] d, input logic [31:0] s,
                         input bit wz, input bit wc, input string tag);
        exp_t e;
        int   n;
        int   pos;
        logic ob, nb;
        @(negedge clk);
        valid_in = 1'b1; dec_mode = dm; dec_width = w; bit_op = op;
        d_val = d; s_val = s; wz_en = wz; wc_en = wc;
        e.tag = tag;
        e.z = m_z;
        e.c = m_c;
        if (dm) begin
            n = int'(w) + 2;
            pos = int'(s & ((32'd1 << n) - 1));
            e.res = 32'd1 << pos;
            if (wz) e.z = s[n];
            if (wc) e.c = s[n+1];
        end else begin
            pos = int'(s[4:0]);
            ob = d[pos];
            case (op)
                3'd1: nb = !ob;
                3'd2: nb = 1'b0;
                3'd3: nb = 1'b1;
                3'd4: nb = m_c;
                3'd5: nb = !m_c;
                3'd6: nb = m_z;
                3'd7: nb = !m_z;
                default: nb = ob;
            endcase
            if (op == 3'd0) e.res = ob ? (32'd1 << pos) : 32'd0;
            else begin
                e.res = d;
                e.res[pos] = nb;
            end
            if (wz) e.z = (e.res == 32'd0);
            if (wc) e.c = ob;
        end
        m_res = e.res; m_z = e.z; m_c = e.c;
        q.push_back(e);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            valid_in = 1'b0;
            d_val = $urandom(); s_val = $urandom();
            wz_en = 1'b1; wc_en = 1'b1; bit_op = 3'd3;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && valid_out) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected valid_out", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(result == e.res, e.tag, "result", result, e.res);
                check(z_flag == e.z, e.tag, "z_flag", {31'd0, z_flag}, {31'd0, e.z});
                check(c_flag == e.c, e.tag, "c_flag", {31'd0, c_flag}, {31'd0, e.c});
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(result == 32'd0 && !z_flag && !c_flag && !valid_out, "R1",
              "reset outputs", {result[28:0], z_flag, c_flag, valid_out}, 32'd0);
        rst = 1'b0;

        // R3 R5 R6: isolate/invert/clear/set over every index
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 32; i++) begin
                issue(1'b0, 2'd0, 3'(op), $urandom(), 32'(i), 1'b1, 1'b1, "R3");
            end
        end
        // R3: single-bit and all-ones patterns, R6 zero result from isolate
        issue(1'b0, 2'd0, 3'd0, 32'h0000_0000, 32'd7, 1'b1, 1'b1, "R6");
        issue(1'b0, 2'd0, 3'd2, 32'h0000_0080, 32'd7, 1'b1, 1'b1, "R6");
        issue(1'b0, 2'd0, 3'd1, 32'hFFFF_FFFF, 32'd31, 1'b1, 1'b1, "R5");

        // R4: conditional sets reading flags set by the previous operation
        for (int i = 0; i < 32; i++) begin
            for (int op = 4; op < 8; op++) begin
                issue(1'b0, 2'd0, 3'd1, $urandom(), $urandom(), 1'b1, 1'b1, "R5");
                issue(1'b0, 2'd0, 3'(op), $urandom(), 32'(i), (op < 6), (op >= 6), "R4");
            end
        end

        // R10: upper source bits ignored
        d = $urandom();
        for (int i = 0; i < 16; i++) begin
            issue(1'b0, 2'd0, 3'(i % 8), d, {$urandom() & 32'hFFFF_FFE0} | 32'd13,
                  1'b1, 1'b1, "R10");
        end

        // R7 R8: decodes of every width, all field values, random upper bits
        for (int w = 0; w < 4; w++) begin
            for (int v = 0; v < 40; v++) begin
                issue(1'b1, 2'(w), 3'($urandom()), $urandom(),
                      ($urandom() & ~32'h3F) | 32'(v % 64), 1'b1, 1'b1, (v % 2) ? "R8" : "R7");
            end
        end

        // R9: flag enables low keep flags
        issue(1'b0, 2'd0, 3'd3, 32'd0, 32'd4, 1'b1, 1'b1, "R9");
        issue(1'b0, 2'd0, 3'd2, 32'd0, 32'd4, 1'b0, 1'b0, "R9");
        issue(1'b1, 2'd3, 3'd0, 32'd0, 32'h0000_00FF, 1'b0, 1'b1, "R9");
        issue(1'b1, 2'd0, 3'd0, 32'd0, 32'h0000_0003, 1'b1, 1'b0, "R9");

        // R9: idle cycles keep result and flags
        idle(6);
        check(q.size() == 0, "R2", "queue drained", 32'(q.size()), 32'd0);
        check(result == m_res, "R9", "idle result", result, m_res);
        check(z_flag == m_z && c_flag == m_c, "R9", "idle flags",
              {30'd0, z_flag, c_flag}, {30'd0, m_z, m_c});
        check(!valid_out, "R2", "valid_out low when idle", {31'd0, valid_out}, 32'd0);

        // R1: reset mid-run clears state
        issue(1'b0, 2'd0, 3'd3, 32'd0, 32'd9, 1'b1, 1'b1, "R3");
        @(negedge clk);
        valid_in = 1'b0;
        void'(q.pop_front());
        rst = 1'b1;
        @(negedge clk);
        check(result == 32'd0 && !z_flag && !c_flag && !valid_out, "R1",
              "reset again", {result[28:0], z_flag, c_flag, valid_out}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule